// File: doc/BRIEF.md
# Single-Wire Temperature and Humidity Reader

This block runs one shared, open-drain data line to a combined temperature and humidity sensor. When a read is requested it pulls the line low for a long start interval, releases it, and then times the sensor's reply. The reply is an acknowledge low and an acknowledge high, followed by forty data bits. Each bit opens with a short low and then carries a high pulse. A short high pulse is a zero and a long one is a one. The block measures every high pulse against a microsecond tick and shifts the result in most significant bit first.

Once the fortieth bit is in, the frame is split into five bytes and the last byte is compared with the modulo-256 sum of the other four. If the frame is sound, the integer humidity and temperature bytes are loaded into the outputs and a one-cycle valid strobe is raised. If the frame is corrupt, or the line stalls, or the acknowledge is missing or too short, the outputs keep their old values and an error flag is raised. The error flag stays up until the next reading begins.

Readings are spaced by a minimum interval, one second by default. A request that arrives before the interval has run out is held, and the reading starts as soon as the interval expires. The host sees only a request pulse, the results and two flags. The line itself is modelled as a drive-low enable and a sampled input. That input passes through a two-stage synchroniser before any edge is detected.

Top module: `hygro_reader`

## Requirements
- R1: While reset is asserted and right after it is released, line_oe, data_valid and csum_err are 0, and humidity and temperature are 0.
- R2: When a reading starts, line_oe goes to 1 and stays at 1 for START_LOW_US microseconds (within one microsecond), then returns to 0.
- R3: The forty data bits are taken most significant first. A bit is 1 when its high pulse is longer than BIT_THRESH_US microseconds and 0 otherwise. On a good frame, humidity takes bits 39:32, temperature takes bits 23:16, and data_valid is 1 for exactly one clock cycle.
- R4: A frame is good when bits 7:0 equal the low eight bits of the sum of bytes 39:32, 31:24, 23:16 and 15:8 (the fraction bytes are included in the sum). On a mismatch, csum_err becomes 1, data_valid stays 0, and humidity and temperature keep their previous values.
- R5: A reading starts only when at least INTERVAL_US microseconds have passed since the previous start. The first request after reset starts at once. An earlier request is held, and its reading starts when the interval expires.
- R6: If, after the release, the sensor does not pull the line low within TIMEOUT_US microseconds, the reading is aborted: csum_err becomes 1, data_valid stays 0, and the outputs are unchanged.
- R7: If any acknowledge or data phase lasts TIMEOUT_US microseconds without the expected edge, the reading is aborted with the same effect as in R6.
- R8: If the acknowledge low or the acknowledge high is shorter than RESP_MIN_US microseconds, the reading is aborted with the same effect as in R6.
- R9: csum_err returns to 0 when the next reading starts, and it is 0 throughout the start low of that reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| read_req | input | 1 | One-cycle request for a new reading |
| line_in | input | 1 | Sampled level of the shared data line |
| line_oe | output | 1 | 1 drives the data line low, 0 releases it |
| humidity | output | 8 | Integer relative humidity from the last good frame |
| temperature | output | 8 | Integer temperature from the last good frame |
| data_valid | output | 1 | One-cycle strobe when a good frame is loaded |
| csum_err | output | 1 | Set by a failed reading, cleared at the next start |

## Verification
Two functions can fall in the same cycle: the expiry of the spacing interval and the arrival of a held request. The bench provokes this by issuing requests at a sweep of delays after the previous start. Some delays fall well before the interval boundary, some just around it and some after it. Each recorded start cycle is then judged against the later of the request cycle and the previous start plus the interval. Good and bad frames, silent, stalled and short-acknowledge sensors are interleaved, so that error clearing at a start and result holding after an abort are seen across successive readings.

// File: rtl/hygro_pkg.sv
package hygro_pkg;
  localparam int FRAME_BITS  = 40;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = FRAME_BITS / BYTE_W;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_HOST_LOW,
    PH_REL_UP,
    PH_WAIT_ACK,
    PH_ACK_LOW,
    PH_ACK_HIGH,
    PH_BIT_LOW,
    PH_BIT_HIGH,
    PH_CHECK
  } phase_e;
endpackage

// File: rtl/hygro_tick.sv
module hygro_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CLK_PER_US <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_PER_US);
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);
      logic [CW-1:0] cnt_q, cnt_nx;

      always_comb begin
        if (cnt_q == LAST) cnt_nx = '0;
        else               cnt_nx = cnt_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/hygro_linesync.sv
module hygro_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_nx;
  logic              prev_q, prev_nx;

  always_comb begin
    sync_nx = {sync_q[STAGES-2:0], line_in};
    prev_nx = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_nx;
      prev_q <= prev_nx;
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/hygro_seq.sv
module hygro_seq
  import hygro_pkg::*;
#(
  parameter int START_LOW_US  = 18000,
  parameter int INTERVAL_US   = 1000000,
  parameter int TIMEOUT_US    = 200,
  parameter int BIT_THRESH_US = 40,
  parameter int RESP_MIN_US   = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic read_req,
  input  logic level,
  input  logic rise,
  input  logic fall,
  output logic line_oe,
  output logic start_pulse,
  output logic shift_en,
  output logic shift_bit,
  output logic frame_end,
  output logic abort
);
  localparam int PH_MAX_I = (START_LOW_US > TIMEOUT_US) ? START_LOW_US : TIMEOUT_US;
  localparam int PH_W     = $clog2(PH_MAX_I + 1);
  localparam int GAP_W    = $clog2(INTERVAL_US + 1);
  localparam int BIT_W    = $clog2(FRAME_BITS + 1);
  localparam logic [PH_W-1:0]  PH_MAX    = PH_W'(PH_MAX_I);
  localparam logic [PH_W-1:0]  START_LIM = PH_W'(START_LOW_US);
  localparam logic [PH_W-1:0]  TO_LIM    = PH_W'(TIMEOUT_US);
  localparam logic [PH_W-1:0]  THR_LIM   = PH_W'(BIT_THRESH_US);
  localparam logic [PH_W-1:0]  MIN_LIM   = PH_W'(RESP_MIN_US);
  localparam logic [GAP_W-1:0] GAP_LIM   = GAP_W'(INTERVAL_US);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] ALL_BITS  = BIT_W'(FRAME_BITS);

  phase_e            state_q, state_nx;
  logic [PH_W-1:0]   ph_q, ph_nx;
  logic [GAP_W-1:0]  gap_q, gap_nx;
  logic [BIT_W-1:0]  bits_q, bits_nx;
  logic              pend_q, pend_nx;
  logic              gap_ok, timeout, fail;

  assign gap_ok  = (gap_q == GAP_LIM);
  assign timeout = (ph_q >= TO_LIM);

  always_comb begin
    state_nx    = state_q;
    start_pulse = 1'b0;
    shift_en    = 1'b0;
    shift_bit   = 1'b0;
    frame_end   = 1'b0;
    fail        = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (pend_q && gap_ok) begin
          state_nx    = PH_HOST_LOW;
          start_pulse = 1'b1;
        end
      end
      PH_HOST_LOW: begin
        if (ph_q >= START_LIM) state_nx = PH_REL_UP;
      end
      PH_REL_UP: begin
        if (level)        state_nx = PH_WAIT_ACK;
        else if (timeout) fail     = 1'b1;
      end
      PH_WAIT_ACK: begin
        if (fall)         state_nx = PH_ACK_LOW;
        else if (timeout) fail     = 1'b1;
      end
      PH_ACK_LOW: begin
        if (rise) begin
          if (ph_q < MIN_LIM) fail     = 1'b1;
          else                state_nx = PH_ACK_HIGH;
        end else if (timeout) begin
          fail = 1'b1;
        end
      end
      PH_ACK_HIGH: begin
        if (fall) begin
          if (ph_q < MIN_LIM) fail     = 1'b1;
          else                state_nx = PH_BIT_LOW;
        end else if (timeout) begin
          fail = 1'b1;
        end
      end
      PH_BIT_LOW: begin
        if (rise)         state_nx = PH_BIT_HIGH;
        else if (timeout) fail     = 1'b1;
      end
      PH_BIT_HIGH: begin
        if (fall) begin
          shift_en  = 1'b1;
          shift_bit = (ph_q > THR_LIM);
          state_nx  = (bits_q == LAST_BIT) ? PH_CHECK : PH_BIT_LOW;
        end else if (timeout) begin
          fail = 1'b1;
        end
      end
      PH_CHECK: begin
        frame_end = 1'b1;
        state_nx  = PH_IDLE;
      end
      default: state_nx = PH_IDLE;
    endcase
    if (fail) state_nx = PH_IDLE;
  end

  assign abort = fail;

  always_comb begin
    if (state_nx != state_q)            ph_nx = '0;
    else if (tick && (ph_q != PH_MAX))  ph_nx = ph_q + PH_W'(1);
    else                                ph_nx = ph_q;

    if (start_pulse)                    gap_nx = '0;
    else if (tick && !gap_ok)           gap_nx = gap_q + GAP_W'(1);
    else                                gap_nx = gap_q;

    if (start_pulse)                    bits_nx = '0;
    else if (shift_en)                  bits_nx = bits_q + BIT_W'(1);
    else                                bits_nx = bits_q;

    pend_nx = (pend_q | read_req) & ~start_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      ph_q    <= '0;
      gap_q   <= GAP_LIM;
      bits_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      ph_q    <= ph_nx;
      gap_q   <= gap_nx;
      bits_q  <= bits_nx;
      pend_q  <= pend_nx;
    end
  end

  assign line_oe = (state_q == PH_HOST_LOW);

  AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= ALL_BITS); // R3
  AST_CHECK_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (bits_q == ALL_BITS)); // R3
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> line_oe); // R2
endmodule

// File: rtl/hygro_frame.sv
module hygro_frame
  import hygro_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_pulse,
  input  logic       shift_en,
  input  logic       shift_bit,
  input  logic       frame_end,
  input  logic       abort,
  output logic [7:0] humidity,
  output logic [7:0] temperature,
  output logic       data_valid,
  output logic       csum_err
);
  localparam int HUM_LSB = (FRAME_BYTES - 1) * BYTE_W;
  localparam int TMP_LSB = (FRAME_BYTES - 3) * BYTE_W;

  logic [FRAME_BITS-1:0] shift_q, shift_nx;
  logic [BYTE_W-1:0]     sum;
  logic                  match, accept;
  logic [7:0]            hum_q, hum_nx, tmp_q, tmp_nx;
  logic                  valid_q, valid_nx, err_q, err_nx;

  always_comb begin
    sum = '0;
    for (int b = 1; b < FRAME_BYTES; b++) begin
      sum = sum + shift_q[b*BYTE_W +: BYTE_W];
    end
  end

  assign match  = (sum == shift_q[BYTE_W-1:0]);
  assign accept = frame_end & match;

  always_comb begin
    shift_nx = shift_en ? {shift_q[FRAME_BITS-2:0], shift_bit} : shift_q;
    hum_nx   = accept ? shift_q[HUM_LSB +: BYTE_W] : hum_q;
    tmp_nx   = accept ? shift_q[TMP_LSB +: BYTE_W] : tmp_q;
    valid_nx = accept;
    if (start_pulse)                        err_nx = 1'b0;
    else if (abort || (frame_end && !match)) err_nx = 1'b1;
    else                                    err_nx = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      hum_q   <= '0;
      tmp_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      shift_q <= shift_nx;
      hum_q   <= hum_nx;
      tmp_q   <= tmp_nx;
      valid_q <= valid_nx;
      err_q   <= err_nx;
    end
  end

  assign humidity    = hum_q;
  assign temperature = tmp_q;
  assign data_valid  = valid_q;
  assign csum_err    = err_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid); // R3
  AST_VALID_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> !csum_err); // R4
  AST_HUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (humidity != $past(humidity)) |-> data_valid); // R4
  AST_TMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (temperature != $past(temperature)) |-> data_valid); // R4
endmodule

// File: rtl/hygro_reader.sv
module hygro_reader #(
  parameter int CLK_PER_US    = 100,
  parameter int START_LOW_US  = 18000,
  parameter int INTERVAL_US   = 1000000,
  parameter int TIMEOUT_US    = 200,
  parameter int BIT_THRESH_US = 40,
  parameter int RESP_MIN_US   = 40,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       read_req,
  input  logic       line_in,
  output logic       line_oe,
  output logic [7:0] humidity,
  output logic [7:0] temperature,
  output logic       data_valid,
  output logic       csum_err
);
  logic tick, level, rise, fall;
  logic start_pulse, shift_en, shift_bit, frame_end, abort;

  hygro_tick #(.CLK_PER_US(CLK_PER_US)) i_tick (
    .clk (clk), .rst_n (rst_n), .tick (tick)
  );

  hygro_linesync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk), .rst_n (rst_n), .line_in (line_in),
    .level (level), .rise (rise), .fall (fall)
  );

  hygro_seq #(
    .START_LOW_US (START_LOW_US), .INTERVAL_US (INTERVAL_US),
    .TIMEOUT_US (TIMEOUT_US), .BIT_THRESH_US (BIT_THRESH_US),
    .RESP_MIN_US (RESP_MIN_US)
  ) i_seq (
    .clk (clk), .rst_n (rst_n), .tick (tick), .read_req (read_req),
    .level (level), .rise (rise), .fall (fall), .line_oe (line_oe),
    .start_pulse (start_pulse), .shift_en (shift_en), .shift_bit (shift_bit),
    .frame_end (frame_end), .abort (abort)
  );

  hygro_frame i_frame (
    .clk (clk), .rst_n (rst_n), .start_pulse (start_pulse),
    .shift_en (shift_en), .shift_bit (shift_bit), .frame_end (frame_end),
    .abort (abort), .humidity (humidity), .temperature (temperature),
    .data_valid (data_valid), .csum_err (csum_err)
  );

  localparam int OE_MAX_I = START_LOW_US * CLK_PER_US * 2 + 4;
  localparam int SP_MAX_I = INTERVAL_US * CLK_PER_US + 1;
  localparam int OE_W     = $clog2(OE_MAX_I + 1);
  localparam int SP_W     = $clog2(SP_MAX_I + 1);
  localparam logic [OE_W-1:0] OE_MAX = OE_W'(OE_MAX_I);
  localparam logic [SP_W-1:0] SP_MAX = SP_W'(SP_MAX_I);
  localparam logic [OE_W-1:0] OE_MIN = OE_W'(START_LOW_US * CLK_PER_US - CLK_PER_US);
  localparam logic [SP_W-1:0] SP_MIN = SP_W'(INTERVAL_US * CLK_PER_US - CLK_PER_US);

  logic [OE_W-1:0] oe_len_q;
  logic [SP_W-1:0] space_q;
  logic            oe_d_q, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_len_q <= '0;
      space_q  <= '0;
      oe_d_q   <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      oe_d_q <= line_oe;
      if (!line_oe)             oe_len_q <= '0;
      else if (oe_len_q != OE_MAX) oe_len_q <= oe_len_q + OE_W'(1);
      if (line_oe && !oe_d_q) begin
        space_q <= SP_W'(1);
        seen_q  <= 1'b1;
      end else if (space_q != SP_MAX) begin
        space_q <= space_q + SP_W'(1);
      end
    end
  end

  AST_START_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_oe && oe_d_q) |-> (oe_len_q >= OE_MIN)); // R2
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && !oe_d_q && seen_q) |-> (space_q >= SP_MIN)); // R5
  AST_ERR_CLEAR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !csum_err); // R9
endmodule

// File: tb/test_hygro_reader.sv
module test_hygro_reader;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 1;
  localparam int START_US   = 60;
  localparam int GAP_US     = 6000;
  localparam int TO_US      = 200;
  localparam int THR_US     = 40;
  localparam int MIN_US     = 40;

  logic       clk = 1'b0;
  logic       rst_n, read_req, sens_low;
  logic       line_oe, data_valid, csum_err;
  logic [7:0] humidity, temperature;
  wire        line_w = !(line_oe || sens_low);

  hygro_reader #(
    .CLK_PER_US (CPU), .START_LOW_US (START_US), .INTERVAL_US (GAP_US),
    .TIMEOUT_US (TO_US), .BIT_THRESH_US (THR_US), .RESP_MIN_US (MIN_US)
  ) i_hygro_reader (
    .clk (clk), .rst_n (rst_n), .read_req (read_req), .line_in (line_w),
    .line_oe (line_oe), .humidity (humidity), .temperature (temperature),
    .data_valid (data_valid), .csum_err (csum_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, errors = 0, checks = 0;
  int valid_cycles = 0, oe_len = 0, start_cyc = 0;
  logic oe_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (data_valid) valid_cycles <= valid_cycles + 1;
    if (line_oe) oe_len <= oe_len + 1;
    if (line_oe && !oe_prev) start_cyc <= cyc;
    oe_prev <= line_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [39:0] make_frame(input int h, input int hf, input int t,
                                             input int tf, input bit bad);
    int cs;
    cs = (h + hf + t + tf + (bad ? 1 : 0)) % 256;
    return {h[7:0], hf[7:0], t[7:0], tf[7:0], cs[7:0]};
  endfunction

  // mode 0: normal, 1: silent, 2: stall mid-frame
  task automatic sensor(input logic [39:0] fr, input int ack_lo, input int ack_hi,
                        input int mode);
    while (!line_oe) @(negedge clk);
    wait_n(2);
    check(csum_err == 1'b0, "R9 error cleared at start", int'(csum_err), 0);
    while (line_oe) @(negedge clk);
    if (mode == 1) return;
    wait_n(25);
    sens_low = 1'b1; wait_n(ack_lo);
    sens_low = 1'b0; wait_n(ack_hi);
    for (int i = 39; i >= 0; i--) begin
      sens_low = 1'b1; wait_n(50);
      if (mode == 2 && i == 34) begin
        wait_n(400);
        sens_low = 1'b0;
        return;
      end
      sens_low = 1'b0;
      wait_n(fr[i] ? (66 + (i % 9)) : (22 + (i % 8)));
    end
    sens_low = 1'b1; wait_n(50);
    sens_low = 1'b0;
  endtask

  int prev_start = -100000;
  logic [7:0] last_h = 8'd0, last_t = 8'd0;

  task automatic transaction(input logic [39:0] fr, input int kind, input int dly);
    int v0, r, exp_s;
    string tag;
    v0 = valid_cycles;
    while (cyc < prev_start + dly) @(negedge clk);
    oe_len = 0;
    read_req = 1'b1; r = cyc;
    @(negedge clk);
    read_req = 1'b0;
    case (kind)
      2:       sensor(fr, 80, 80, 1);
      3:       sensor(fr, 80, 80, 2);
      4:       sensor(fr, 20, 80, 0);
      default: sensor(fr, 80, 80, 0);
    endcase
    wait_n(300);
    exp_s = (r + 2 > prev_start + GAP_US + 1) ? r + 2 : prev_start + GAP_US + 1;
    check((start_cyc - exp_s <= 3) && (exp_s - start_cyc <= 3), "R5 start cycle",
          start_cyc, exp_s);
    check((oe_len >= START_US * CPU - 2) && (oe_len <= START_US * CPU + 2),
          "R2 start low length", oe_len, START_US * CPU);
    check(line_oe == 1'b0, "R2 line released", int'(line_oe), 0);
    if (kind == 0) begin
      check(valid_cycles - v0 == 1, "R3 valid pulse cycles", valid_cycles - v0, 1);
      check(humidity == fr[39:32], "R3 humidity", humidity, fr[39:32]);
      check(temperature == fr[23:16], "R3 temperature", temperature, fr[23:16]);
      check(csum_err == 1'b0, "R4 no error on good frame", int'(csum_err), 0);
      last_h = fr[39:32];
      last_t = fr[23:16];
    end else begin
      tag = (kind == 1) ? "R4" : (kind == 2) ? "R6" : (kind == 3) ? "R7" : "R8";
      check(valid_cycles - v0 == 0, {tag, " no valid"}, valid_cycles - v0, 0);
      check(csum_err == 1'b1, {tag, " error flag"}, int'(csum_err), 1);
      check(humidity == last_h, {tag, " humidity held"}, humidity, last_h);
      check(temperature == last_t, {tag, " temperature held"}, temperature, last_t);
    end
    prev_start = start_cyc;
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int kinds[15] = '{0, 0, 1, 0, 2, 0, 3, 0, 4, 0, 0, 1, 0, 0, 0};
    int g;
    logic [39:0] fr;
    rst_n = 1'b0; read_req = 1'b0; sens_low = 1'b0;
    wait_n(3);
    check(line_oe == 1'b0, "R1 line_oe in reset", int'(line_oe), 0);
    check(data_valid == 1'b0, "R1 data_valid in reset", int'(data_valid), 0);
    check(csum_err == 1'b0, "R1 csum_err in reset", int'(csum_err), 0);
    check(humidity == 8'd0, "R1 humidity in reset", humidity, 0);
    check(temperature == 8'd0, "R1 temperature in reset", temperature, 0);
    rst_n = 1'b1;
    wait_n(3);
    check(line_oe == 1'b0, "R1 line_oe after reset", int'(line_oe), 0);
    g = 0;
    for (int k = 0; k < 15; k++) begin
      if (g == 9)
        fr = make_frame(255, 255, 255, 255, kinds[k] == 1);
      else
        fr = make_frame((g * 53 + 7) % 256, (g * 19) % 256, (g * 97 + 200) % 256,
                        (255 - g * 31) % 256, kinds[k] == 1);
      transaction(fr, kinds[k], 5000 + (k % 6) * 250);
      if (kinds[k] == 0) g++;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule